// File: doc/BRIEF.md
# PCI Configuration Header Register File

This block holds the 256-byte configuration space of a simple network-class function. A host bus agent issues accesses of one to four bytes at a byte address. Byte k of the access lands on address (addr + k) mod 256 and uses data lane k. At reset the space loads an identity (vendor, device, revision, class) and a small set of defaults. Every other byte starts at zero.

Writes follow a per-byte policy. A few bytes are read-only. Two address windows discard the whole write. The low byte of the single I/O base address register is forced to mark I/O space. The block exports the decoded 16-byte-aligned I/O base. It also pulses a strobe for one cycle whenever a write really alters the base register, so that an outside decoder can move the device's 16-byte I/O window. Accesses with an illegal length are rejected.

Top module: `pcicfg_regfile`

## Requirements
- R1: After reset, bytes 0x00–0x01 hold VENDOR_ID (little-endian), bytes 0x02–0x03 hold DEVICE_ID, byte 0x08 holds REVISION (default 0x01), byte 0x0B holds 0x02 and bytes 0x09–0x0A hold 0x00.
- R2: After reset, byte 0x04 = 0x05, byte 0x05 = 0x00, byte 0x06 = 0x80, byte 0x07 = 0x02, byte 0x0D = 0x20, byte 0x0E = 0x00, bytes 0x20–0x23 read 0x00000001, byte 0x3C = 0x00, byte 0x3D = 0x01, byte 0x6A = 0x01 and byte 0xC1 = 0x20. All other bytes are 0x00.
- R3: A read with length L in 1..4 returns byte (addr+k) mod 256 in rd_data[8k+7:8k] for k < L and zero in the higher lanes. The result appears on rd_data on the clock edge that accepts the access and holds until the next read.
- R4: A write with length L in 1..4 stores wr_data[8k+7:8k] into byte (addr+k) mod 256 for each k < L, unless R5, R6 or R7 apply. The stored byte reads back unchanged; this includes the interrupt line at 0x3C.
- R5: A write whose start address lies in 0x10–0x1F or 0x24–0x33 changes no byte and raises no base-change strobe.
- R6: Bytes 0x05, 0x06 and 0x3D ignore writes. Other lanes of the same access are still written.
- R7: A byte written to 0x20 is stored as (value & 0xFC) | 0x01, so bit 0 of the base register always reads 1.
- R8: base_changed is high for exactly the one cycle after the edge that accepts a write whose stored bytes differ from the old contents of 0x20–0x23. It stays low for every other access and for idle cycles, including a write that stores an identical value.
- R9: io_base equals {byte 0x21, byte 0x20[7:4], 4'h0} of the stored contents and follows a base write from the edge that accepts it.
- R10: An access with length 0 or greater than 4 returns 0xFFFFFFFF on rd_data if it is a read, changes no byte, and raises no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Access request for this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 8 | Byte address of lane 0 |
| acc_len | input | 3 | Access length in bytes |
| acc_wdata | input | 32 | Write data, lane k in bits [8k+7:8k] |
| rd_data | output | 32 | Registered read result |
| io_base | output | 16 | 16-byte-aligned I/O base decoded from the base register |
| base_changed | output | 1 | One-cycle pulse after a write that altered the base register |

## Verification
Every result of this block is due one clock edge after the access is presented: rd_data, the stored bytes behind io_base, and the base_changed pulse all come from registers loaded on the accepting edge. The bench drives each access on a falling edge. A behavioural model commits the same access on the next rising edge. The bench compares rd_data, io_base and base_changed with the model on every falling edge, half a cycle after both have settled. Directed checks with literal expected values are taken at that same falling edge. A further idle cycle confirms that the strobe has dropped.

// File: rtl/pcicfg_pkg.sv
package pcicfg_pkg;

    localparam int CFG_BYTES = 256;
    localparam int CFG_AW    = $clog2(CFG_BYTES);

    typedef logic [7:0]                 cfg_byte_t;
    typedef logic [CFG_AW-1:0]          cfg_addr_t;
    typedef logic [CFG_BYTES-1:0][7:0]  cfg_image_t;

    // Start addresses whose writes are discarded as a whole.
    function automatic logic write_window_blocked(input cfg_addr_t a);
        return ((a >= 8'h10) && (a <= 8'h1F)) || ((a >= 8'h24) && (a <= 8'h33));
    endfunction

    function automatic logic byte_is_locked(input cfg_addr_t a);
        return (a == 8'h05) || (a == 8'h06) || (a == 8'h3D);
    endfunction

    function automatic logic byte_in_bar(input cfg_addr_t a);
        return (a >= 8'h20) && (a <= 8'h23);
    endfunction

    function automatic cfg_image_t power_on_image(input logic [15:0] ven,
                                                  input logic [15:0] dev,
                                                  input logic [7:0]  rev);
        cfg_image_t img;
        img         = '0;
        img[8'h00]  = ven[7:0];
        img[8'h01]  = ven[15:8];
        img[8'h02]  = dev[7:0];
        img[8'h03]  = dev[15:8];
        img[8'h04]  = 8'h05;
        img[8'h06]  = 8'h80;
        img[8'h07]  = 8'h02;
        img[8'h08]  = rev;
        img[8'h0B]  = 8'h02;
        img[8'h0D]  = 8'h20;
        img[8'h20]  = 8'h01;
        img[8'h3D]  = 8'h01;
        img[8'h6A]  = 8'h01;
        img[8'hC1]  = 8'h20;
        return img;
    endfunction

endpackage

// File: rtl/cfg_lane_map.sv
module cfg_lane_map
    import pcicfg_pkg::*;
#(
    parameter int LANES = 4,
    parameter int LEN_W = 3
) (
    input  cfg_addr_t                   base_addr,
    input  logic [LEN_W-1:0]            len,
    output logic                        len_ok,
    output logic [LANES-1:0]            lane_en,
    output logic [LANES-1:0][CFG_AW-1:0] lane_idx
);
    assign len_ok = (len != '0) && (int'(len) <= LANES);

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign lane_idx[k] = base_addr + CFG_AW'(k);
        assign lane_en[k]  = len_ok && (int'(len) > k);
    end
endmodule

// File: rtl/cfg_byte_policy.sv
module cfg_byte_policy
    import pcicfg_pkg::*;
(
    input  cfg_addr_t idx,
    input  logic      wr_en,
    input  cfg_byte_t new_val,
    input  cfg_byte_t old_val,
    output logic      store,
    output cfg_byte_t store_val,
    output logic      bar_delta
);
    always_comb begin
        store     = wr_en && !byte_is_locked(idx);
        store_val = new_val;
        if (idx == 8'h20) begin
            store_val = (new_val & 8'hFC) | 8'h01;
        end
        bar_delta = store && byte_in_bar(idx) && (store_val != old_val);
    end
endmodule

// File: rtl/pcicfg_regfile.sv
module pcicfg_regfile
    import pcicfg_pkg::*;
#(
    parameter logic [15:0] VENDOR_ID = 16'h1D0F,
    parameter logic [15:0] DEVICE_ID = 16'h0A51,
    parameter logic [7:0]  REVISION  = 8'h01,
    parameter int          LANES     = 4,
    parameter int          LEN_W     = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 acc_valid,
    input  logic                 acc_write,
    input  logic [CFG_AW-1:0]    acc_addr,
    input  logic [LEN_W-1:0]     acc_len,
    input  logic [8*LANES-1:0]   acc_wdata,
    output logic [8*LANES-1:0]   rd_data,
    output logic [15:0]          io_base,
    output logic                 base_changed
);
    localparam int DW = 8 * LANES;

    typedef struct packed {
        cfg_image_t     mem;
        logic [DW-1:0]  rd;
        logic           bchg;
    } state_t;

    state_t d, q;

    logic                        len_ok;
    logic [LANES-1:0]            lane_en;
    logic [LANES-1:0][CFG_AW-1:0] lane_idx;
    logic [LANES-1:0]            lane_store;
    logic [LANES-1:0][7:0]       lane_val;
    logic [LANES-1:0]            lane_bar_delta;
    logic                        write_go;

    cfg_lane_map #(.LANES(LANES), .LEN_W(LEN_W)) u_map (
        .base_addr (acc_addr),
        .len       (acc_len),
        .len_ok    (len_ok),
        .lane_en   (lane_en),
        .lane_idx  (lane_idx)
    );

    assign write_go = acc_valid && acc_write && !write_window_blocked(acc_addr);

    for (genvar k = 0; k < LANES; k++) begin : g_policy
        cfg_byte_policy u_pol (
            .idx       (lane_idx[k]),
            .wr_en     (write_go && lane_en[k]),
            .new_val   (acc_wdata[8*k +: 8]),
            .old_val   (q.mem[lane_idx[k]]),
            .store     (lane_store[k]),
            .store_val (lane_val[k]),
            .bar_delta (lane_bar_delta[k])
        );
    end

    always_comb begin
        d      = q;
        d.bchg = 1'b0;
        if (acc_valid && !acc_write) begin
            if (!len_ok) begin
                d.rd = '1;
            end else begin
                for (int k = 0; k < LANES; k++) begin
                    d.rd[8*k +: 8] = lane_en[k] ? q.mem[lane_idx[k]] : 8'h00;
                end
            end
        end
        for (int k = 0; k < LANES; k++) begin
            if (lane_store[k]) begin
                d.mem[lane_idx[k]] = lane_val[k];
            end
        end
        d.bchg = |lane_bar_delta;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.mem  <= power_on_image(VENDOR_ID, DEVICE_ID, REVISION);
            q.rd   <= '0;
            q.bchg <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign rd_data      = q.rd;
    assign base_changed = q.bchg;
    assign io_base      = {q.mem[8'h21], q.mem[8'h20][7:4], 4'h0};

    // Locked bytes never move once out of reset.
    p_locked_bytes_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $stable({q.mem[8'h05], q.mem[8'h06], q.mem[8'h3D]}));

    // Base register always flags I/O space.
    p_bar_io_space_r7: assert property (@(posedge clk) disable iff (!rst_n)
        q.mem[8'h20][1:0] == 2'b01);

    // A strobe only accompanies a real change of the base register.
    p_strobe_means_change_r8: assert property (@(posedge clk) disable iff (!rst_n)
        base_changed |-> (q.mem[8'h23:8'h20] != $past(q.mem[8'h23:8'h20])));

    // Idle cycles and reads leave no strobe behind.
    p_strobe_needs_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_valid && acc_write) |=> !base_changed);

    // Blocked windows change nothing.
    p_blocked_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_write && write_window_blocked(acc_addr)) |=> ($stable(q.mem) && !base_changed));

    // Bad lengths: all-ones read data, storage untouched.
    p_bad_length_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !len_ok) |=> ($stable(q.mem) && !base_changed &&
                                    ($past(acc_write) || rd_data == '1)));
endmodule

// File: tb/tb_pcicfg_regfile.sv
module tb_pcicfg_regfile;
    localparam logic [15:0] VEN = 16'h1D0F;
    localparam logic [15:0] DEV = 16'h0A51;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic [7:0]  acc_addr = '0;
    logic [2:0]  acc_len = '0;
    logic [31:0] acc_wdata = '0;
    logic [31:0] rd_data;
    logic [15:0] io_base;
    logic        base_changed;

    int n_checks = 0;
    int n_fail   = 0;
    string phase = "R2";

    logic [7:0]  mm [256];
    logic [31:0] exp_rd = '0;
    logic        exp_bchg = 1'b0;
    logic        armed = 1'b0;

    always #10 clk = ~clk;

    pcicfg_regfile #(.VENDOR_ID(VEN), .DEVICE_ID(DEV)) dut (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_addr(acc_addr), .acc_len(acc_len), .acc_wdata(acc_wdata),
        .rd_data(rd_data), .io_base(io_base), .base_changed(base_changed)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
        n_checks++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, expv);
        end
    endtask

    // Behavioural reference, committed on each rising edge.
    always @(posedge clk) begin
        if (rst_n) begin
            exp_bchg <= 1'b0;
            if (acc_valid) begin
                if (acc_len == 0 || acc_len > 4) begin
                    if (!acc_write) exp_rd <= 32'hFFFF_FFFF;
                end else if (!acc_write) begin
                    logic [31:0] r;
                    r = '0;
                    for (int k = 0; k < int'(acc_len); k++)
                        r[8*k +: 8] = mm[(int'(acc_addr) + k) % 256];
                    exp_rd <= r;
                end else if (!((acc_addr >= 8'h10 && acc_addr <= 8'h1F) ||
                               (acc_addr >= 8'h24 && acc_addr <= 8'h33))) begin
                    logic chg;
                    chg = 1'b0;
                    for (int k = 0; k < int'(acc_len); k++) begin
                        int ix;
                        logic [7:0] v;
                        ix = (int'(acc_addr) + k) % 256;
                        v  = acc_wdata[8*k +: 8];
                        if (ix == 'h20) v = (v & 8'hFC) | 8'h01;
                        if (ix != 'h05 && ix != 'h06 && ix != 'h3D) begin
                            if (ix >= 'h20 && ix <= 'h23 && v != mm[ix]) chg = 1'b1;
                            mm[ix] = v;
                        end
                    end
                    exp_bchg <= chg;
                end
            end
        end
    end

    // Per-clock comparison against the model.
    always @(negedge clk) begin
        if (armed) begin
            check({phase, " rd_data"}, rd_data, exp_rd);
            check({"R9/", phase, " io_base"}, {16'h0, io_base}, {16'h0, mm[8'h21], mm[8'h20][7:4], 4'h0});
            check({"R8/", phase, " base_changed"}, {31'h0, base_changed}, {31'h0, exp_bchg});
        end
    end

    task automatic acc(input logic w, input logic [7:0] a, input logic [2:0] l, input logic [31:0] wd);
        acc_valid = 1'b1; acc_write = w; acc_addr = a; acc_len = l; acc_wdata = wd;
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0;
    endtask

    task automatic rd_expect(input string req, input logic [7:0] a, input logic [2:0] l, input logic [31:0] expv);
        phase = req;
        acc(1'b0, a, l, 32'h0);
        check(req, rd_data, expv);
    endtask

    task automatic idle();
        @(negedge clk);
    endtask

    initial begin
        #(20 * 200000);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) mm[i] = 8'h00;
        mm['h00] = VEN[7:0]; mm['h01] = VEN[15:8];
        mm['h02] = DEV[7:0]; mm['h03] = DEV[15:8];
        mm['h04] = 8'h05; mm['h06] = 8'h80; mm['h07] = 8'h02;
        mm['h08] = 8'h01; mm['h0B] = 8'h02; mm['h0D] = 8'h20;
        mm['h20] = 8'h01; mm['h3D] = 8'h01; mm['h6A] = 8'h01; mm['hC1] = 8'h20;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        armed = 1'b1;

        // Reset state
        check("R9 reset io_base", {16'h0, io_base}, 32'h0);
        check("R8 reset strobe", {31'h0, base_changed}, 32'h0);
        rd_expect("R1", 8'h00, 3'd4, {DEV, VEN});
        rd_expect("R1", 8'h08, 3'd4, 32'h0200_0001);
        rd_expect("R2", 8'h04, 3'd4, 32'h0280_0005);
        rd_expect("R2", 8'h0C, 3'd4, 32'h0000_2000);
        rd_expect("R2", 8'h20, 3'd4, 32'h0000_0001);
        rd_expect("R2", 8'h3C, 3'd2, 32'h0000_0100);
        rd_expect("R2", 8'h6A, 3'd1, 32'h0000_0001);
        rd_expect("R2", 8'hC1, 3'd1, 32'h0000_0020);
        rd_expect("R2", 8'h80, 3'd4, 32'h0000_0000);

        // Lane placement and wrap
        rd_expect("R3", 8'h02, 3'd2, {16'h0, DEV});
        rd_expect("R3", 8'h01, 3'd3, {8'h0, DEV, VEN[15:8]});
        rd_expect("R3", 8'hFE, 3'd4, {VEN, 16'h0});

        // Plain writes
        phase = "R4"; acc(1'b1, 8'h3C, 3'd1, 32'h0000_000B);
        rd_expect("R4", 8'h3C, 3'd1, 32'h0000_000B);
        phase = "R4"; acc(1'b1, 8'h40, 3'd4, 32'hDEAD_BEEF);
        rd_expect("R4", 8'h40, 3'd4, 32'hDEAD_BEEF);
        phase = "R4"; acc(1'b1, 8'hFF, 3'd2, 32'h0000_A55A);
        rd_expect("R4", 8'hFF, 3'd1, 32'h0000_005A);

        // Read-only bytes
        phase = "R6"; acc(1'b1, 8'h04, 3'd4, 32'hFFFF_FFFF);
        rd_expect("R6", 8'h04, 3'd4, 32'hFF80_00FF);
        phase = "R6"; acc(1'b1, 8'h3C, 3'd2, 32'h0000_0722);
        rd_expect("R6", 8'h3C, 3'd2, 32'h0000_0122);

        // Blocked windows
        phase = "R5"; acc(1'b1, 8'h10, 3'd4, 32'h1234_5678);
        rd_expect("R5", 8'h10, 3'd4, 32'h0);
        phase = "R5"; acc(1'b1, 8'h30, 3'd4, 32'h8765_4321);
        rd_expect("R5", 8'h30, 3'd4, 32'h0);
        phase = "R5"; acc(1'b1, 8'h1E, 3'd4, 32'hFFFF_FFFF);
        check("R5 no strobe", {31'h0, base_changed}, 32'h0);
        rd_expect("R5", 8'h20, 3'd4, 32'h0000_0001);
        phase = "R5"; acc(1'b1, 8'h34, 3'd1, 32'h0000_0066);
        rd_expect("R5", 8'h34, 3'd1, 32'h0000_0066);

        // Base register
        phase = "R7"; acc(1'b1, 8'h20, 3'd4, 32'h0000_C0FF);
        check("R8 strobe on change", {31'h0, base_changed}, 32'h1);
        check("R9 io_base", {16'h0, io_base}, 32'h0000_C0F0);
        idle();
        check("R8 strobe one cycle", {31'h0, base_changed}, 32'h0);
        rd_expect("R7", 8'h20, 3'd4, 32'h0000_C0FD);
        phase = "R8"; acc(1'b1, 8'h20, 3'd1, 32'h0000_00FE);
        check("R8 same value no strobe", {31'h0, base_changed}, 32'h0);
        phase = "R8"; acc(1'b1, 8'h22, 3'd1, 32'h0000_0001);
        check("R8 upper byte strobe", {31'h0, base_changed}, 32'h1);
        phase = "R9"; acc(1'b1, 8'h20, 3'd2, 32'h0000_3A42);
        check("R9 io_base moved", {16'h0, io_base}, 32'h0000_3A40);
        check("R8 back-to-back strobe", {31'h0, base_changed}, 32'h1);

        // Illegal lengths
        rd_expect("R10", 8'h00, 3'd0, 32'hFFFF_FFFF);
        rd_expect("R10", 8'h08, 3'd5, 32'hFFFF_FFFF);
        phase = "R10"; acc(1'b1, 8'h40, 3'd7, 32'h0102_0304);
        rd_expect("R10", 8'h40, 3'd4, 32'hDEAD_BEEF);
        phase = "R10"; acc(1'b1, 8'h20, 3'd6, 32'h0000_0000);
        check("R10 no strobe", {31'h0, base_changed}, 32'h0);

        idle();
        idle();
        armed = 1'b0;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule